// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block takes one 8-byte segment descriptor, given as a lower and an upper 32-bit word, together with one memory access. The access is described by a 32-bit offset, a byte count of 1, 2 or 4, and a kind: read, write or execute. The block splits the descriptor into base, limit and attribute fields. It scales the limit by the granularity flag and works out the valid offset range, which is inverted for expand-down data segments. It then checks that every byte of the access lies inside that range and that the segment type allows the access kind.

The outcome is registered and appears one cycle after the request, with a response-valid strobe. It is exactly one of three flags: access allowed, general-protection fault or not-present fault. When the access is allowed, the linear address (base plus offset) is driven with it. A pipeline stage ahead of the address generator can issue one check per cycle.

Top module: `seg_access_check`

## Requirements
- R1: Field positions. The base is {hi[31:24], hi[7:0], lo[31:16]} and the raw limit is {hi[19:16], lo[15:0]}. The other fields are: G hi[23], D/B hi[22], P hi[15], S hi[12], code/data hi[11] (1 = code), E or C hi[10], W or R hi[9]. When the access is allowed, `lin_addr_o` is (base + offset) mod 2^32. Otherwise it is 0.
- R2: `rsp_valid_o` is high in the cycle after the one in which `req_valid_i` is sampled high. When there is no response, all flags and `lin_addr_o` are 0. Reset clears every output.
- R3: `size_i` encoding: 0 = 1 byte, 1 = 2 bytes, 2 and 3 = 4 bytes. `kind_i` encoding: 0 = read, 1 = write, 2 = execute, 3 = read.
- R4: With G=0 the effective limit is the raw limit. With G=1 it is (raw << 12) | 0xFFF, so a raw limit of 0 allows offsets 0..4095.
- R5: A code segment, or a data segment with E=0, accepts an access only if offset + size − 1 is at most the effective limit. The sum is formed in 33 bits, so an access that wraps past 0xFFFF_FFFF faults.
- R6: A data segment with E=1 accepts an access only if the offset exceeds the effective limit and offset + size − 1 does not exceed 0xFFFF (D/B=0) or 0xFFFF_FFFF (D/B=1).
- R7: With P=0, every access reports only the not-present fault, whatever the type or range.
- R8: For a code segment, execute is allowed, a write is a general-protection fault, and a read faults when R=0.
- R9: For a data segment, execute is a general-protection fault, a write faults when W=0, and a read is allowed.
- R10: With P=1 and S=0, every access is a general-protection fault.
- R11: On every response, exactly one of `ok_o`, `gp_o` and `np_o` is high. The not-present fault takes priority over the type checks, and the type checks take priority over the range checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Check request strobe |
| desc_lo_i | input | 32 | Lower descriptor word |
| desc_hi_i | input | 32 | Upper descriptor word |
| offset_i | input | 32 | Access offset within the segment |
| size_i | input | 2 | Access size code |
| kind_i | input | 2 | Access kind code |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| ok_o | output | 1 | Access allowed |
| gp_o | output | 1 | General-protection fault |
| np_o | output | 1 | Segment-not-present fault |
| lin_addr_o | output | 32 | Linear address when allowed, else 0 |

## Verification
Random descriptors are drawn with offsets placed close to the effective limit, so single-byte and multi-byte accesses land on both sides of the boundary. This separates a check of the first byte alone from a check of the last byte. Directed vectors cover these cases:
- the granularity scaling at raw limit 0;
- a 4-byte access that wraps past the top of the address space;
- both expand-down upper bounds;
- each type and permission combination, including the reserved codes for size and kind.

Vectors with P=0 on otherwise illegal accesses show that the fault priority is applied, not merely that some fault is raised. Vectors with a base near the top of the address space show the address wrapping modulo 2^32.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int ADDR_W   = 32;
  localparam int LIM_W    = 20;
  localparam int PAGE_SH  = 12;
  localparam int SMALL_W  = 16;
  localparam int SIZE_W   = 2;
  localparam int SPAN_W   = 3;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              big;
    logic              lmode;
    logic              avail;
    logic              present;
    logic [1:0]        dpl;
    logic              user;
    logic              code;
    logic              dir_conf;
    logic              wr_rd;
    logic              accessed;
  } seg_attr_t;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_chk_pkg::*;
(
  input  logic [31:0] desc_lo_i,
  input  logic [31:0] desc_hi_i,
  output seg_attr_t   attr_o
);
  always_comb begin
    attr_o.base     = {desc_hi_i[31:24], desc_hi_i[7:0], desc_lo_i[31:16]};
    attr_o.limit    = {desc_hi_i[19:16], desc_lo_i[15:0]};
    attr_o.gran     = desc_hi_i[23];
    attr_o.big      = desc_hi_i[22];
    attr_o.lmode    = desc_hi_i[21];
    attr_o.avail    = desc_hi_i[20];
    attr_o.present  = desc_hi_i[15];
    attr_o.dpl      = desc_hi_i[14:13];
    attr_o.user     = desc_hi_i[12];
    attr_o.code     = desc_hi_i[11];
    attr_o.dir_conf = desc_hi_i[10];
    attr_o.wr_rd    = desc_hi_i[9];
    attr_o.accessed = desc_hi_i[8];
  end
endmodule

// File: rtl/seg_perm_check.sv
module seg_perm_check
  import seg_chk_pkg::*;
(
  input  seg_attr_t  attr_i,
  input  acc_kind_e  kind_i,
  output logic       fault_o
);
  always_comb begin
    fault_o = 1'b0;
    if (!attr_i.user) begin
      fault_o = 1'b1;
    end else if (attr_i.code) begin
      unique case (kind_i)
        ACC_WR:         fault_o = 1'b1;
        ACC_EX:         fault_o = 1'b0;
        ACC_RD, ACC_RSV: fault_o = !attr_i.wr_rd;
        default:        fault_o = 1'b1;
      endcase
    end else begin
      unique case (kind_i)
        ACC_WR:         fault_o = !attr_i.wr_rd;
        ACC_EX:         fault_o = 1'b1;
        ACC_RD, ACC_RSV: fault_o = 1'b0;
        default:        fault_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_chk_pkg::*;
(
  input  seg_attr_t         attr_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              fault_o
);
  localparam int PAD_W = ADDR_W - LIM_W;
  localparam int HI_W  = ADDR_W - SMALL_W;

  logic [ADDR_W-1:0] eff_lim;
  logic [ADDR_W-1:0] top_bound;
  logic [ADDR_W:0]   last_byte;
  logic [SPAN_W-1:0] span_m1;
  logic              expand_dn, up_ok, dn_ok;

  always_comb begin
    unique case (size_i)
      2'd0:    span_m1 = SPAN_W'(0);
      2'd1:    span_m1 = SPAN_W'(1);
      default: span_m1 = SPAN_W'(3);
    endcase
  end

  // granularity scaling: low bits filled with ones
  assign eff_lim   = attr_i.gran ? {attr_i.limit, {PAGE_SH{1'b1}}}
                                 : {{PAD_W{1'b0}}, attr_i.limit};
  assign top_bound = attr_i.big ? {ADDR_W{1'b1}} : {{HI_W{1'b0}}, {SMALL_W{1'b1}}};
  assign last_byte = {1'b0, offset_i} + {{(ADDR_W+1-SPAN_W){1'b0}}, span_m1};
  assign expand_dn = !attr_i.code && attr_i.dir_conf;
  assign up_ok     = last_byte <= {1'b0, eff_lim};
  assign dn_ok     = (offset_i > eff_lim) && (last_byte <= {1'b0, top_bound});
  assign fault_o   = expand_dn ? !dn_ok : !up_ok;
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       desc_lo_i,
  input  logic [31:0]       desc_hi_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  output logic              rsp_valid_o,
  output logic              ok_o,
  output logic              gp_o,
  output logic              np_o,
  output logic [ADDR_W-1:0] lin_addr_o
);
  seg_attr_t attr;
  logic      perm_fault, lim_fault;
  logic      np_d, gp_d, ok_d;

  seg_desc_decode u_dec (
    .desc_lo_i (desc_lo_i),
    .desc_hi_i (desc_hi_i),
    .attr_o    (attr)
  );

  seg_perm_check u_perm (
    .attr_i  (attr),
    .kind_i  (acc_kind_e'(kind_i)),
    .fault_o (perm_fault)
  );

  seg_limit_check u_lim (
    .attr_i   (attr),
    .offset_i (offset_i),
    .size_i   (size_i),
    .fault_o  (lim_fault)
  );

  // priority: not-present, then type, then range
  assign np_d = !attr.present;
  assign gp_d = attr.present && (perm_fault || lim_fault);
  assign ok_d = attr.present && !perm_fault && !lim_fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      ok_o        <= 1'b0;
      gp_o        <= 1'b0;
      np_o        <= 1'b0;
      lin_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      ok_o        <= req_valid_i && ok_d;
      gp_o        <= req_valid_i && gp_d;
      np_o        <= req_valid_i && np_d;
      lin_addr_o  <= (req_valid_i && ok_d) ? attr.base + offset_i : '0;
    end
  end
endmodule

// File: rtl/seg_access_check_sva.sv
module seg_access_check_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] desc_hi_i,
  input logic [1:0]  kind_i,
  input logic        rsp_valid_o,
  input logic        ok_o,
  input logic        gp_o,
  input logic        np_o,
  input logic [31:0] lin_addr_o
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);  // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(ok_o || gp_o || np_o) && lin_addr_o == '0);  // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({ok_o, gp_o, np_o}) == 1);  // R11
  AST_ADDR_ONLY_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_o |-> lin_addr_o == '0);  // R1
  AST_NP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !desc_hi_i[15]) |=> np_o);  // R7
  AST_SYS_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && desc_hi_i[15] && !desc_hi_i[12]) |=> gp_o);  // R10
  AST_CODE_WR_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && desc_hi_i[15] && desc_hi_i[12] && desc_hi_i[11] && kind_i == 2'd1) |=> gp_o);  // R8
  AST_DATA_EX_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && desc_hi_i[15] && desc_hi_i[12] && !desc_hi_i[11] && kind_i == 2'd2) |=> gp_o);  // R9
endmodule

bind seg_access_check seg_access_check_sva chk_i (.*);

// File: tb/seg_access_check_tb_top.sv
module seg_access_check_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] desc_lo_i = '0, desc_hi_i = '0, offset_i = '0;
  logic [1:0]  size_i = '0, kind_i = '0;
  logic        rsp_valid_o, ok_o, gp_o, np_o;
  logic [31:0] lin_addr_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  seg_access_check dut_i (.*);

  function automatic logic [31:0] mk_lo(logic [31:0] base, logic [19:0] lim);
    return {base[15:0], lim[15:0]};
  endfunction
  // typ = {code, e/c, w/r, accessed}
  function automatic logic [31:0] mk_hi(logic [31:0] base, logic [19:0] lim, logic g, logic db,
                                        logic p, logic s, logic [3:0] typ);
    return {base[31:24], g, db, 2'b00, lim[19:16], p, 2'b00, s, typ, base[23:16]};
  endfunction

  // returns {ok, gp, np, addr}
  function automatic logic [34:0] model(logic [31:0] lo, logic [31:0] hi, logic [31:0] off,
                                        logic [1:0] sz, logic [1:0] kd);
    logic [31:0] base, eff, top;
    logic [32:0] last;
    logic        pf, lf, code;
    base = {hi[31:24], hi[7:0], lo[31:16]};
    eff  = hi[23] ? ({12'd0, hi[19:16], lo[15:0]} << 12) | 32'hFFF : {12'd0, hi[19:16], lo[15:0]};
    last = {1'b0, off} + ((sz == 2'd0) ? 33'd0 : (sz == 2'd1) ? 33'd1 : 33'd3);
    code = hi[11];
    if (!hi[15]) return {3'b001, 32'd0};
    if (!hi[12]) pf = 1;
    else if (code) pf = (kd == 2'd1) ? 1'b1 : (kd == 2'd2) ? 1'b0 : !hi[9];
    else pf = (kd == 2'd1) ? !hi[9] : (kd == 2'd2);
    top = hi[22] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    if (!code && hi[10]) lf = !(off > eff && last <= {1'b0, top});
    else lf = !(last <= {1'b0, eff});
    if (pf || lf) return {3'b010, 32'd0};
    return {3'b100, base + off};
  endfunction

  task automatic apply(input logic [31:0] lo, hi, off, input logic [1:0] sz, kd, input string tag);
    logic [34:0] exp_v;
    exp_v = model(lo, hi, off, sz, kd);
    desc_lo_i = lo; desc_hi_i = hi; offset_i = off; size_i = sz; kind_i = kd;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n_chk++;
    if (rsp_valid_o !== 1'b1 || {ok_o, gp_o, np_o, lin_addr_o} !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got v=%b ok/gp/np=%b%b%b addr=%h, exp v=1 ok/gp/np=%b addr=%h",
               tag, rsp_valid_o, ok_o, gp_o, np_o, lin_addr_o, exp_v[34:32], exp_v[31:0]);
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk_i);
    n_chk++;
    if ({rsp_valid_o, ok_o, gp_o, np_o, lin_addr_o} !== 36'd0) begin
      n_bad++;
      $display("FAIL %s: got v=%b ok/gp/np=%b%b%b addr=%h, exp all zero",
               tag, rsp_valid_o, ok_o, gp_o, np_o, lin_addr_o);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] b;
    process::self().srandom(32'd1234);
    b = 32'h1234_5678;
    #1;
    n_chk++;
    if ({rsp_valid_o, ok_o, gp_o, np_o, lin_addr_o} !== 36'd0) begin
      n_bad++; $display("FAIL R2 reset: got %b%b%b%b %h, exp zeros", rsp_valid_o, ok_o, gp_o, np_o, lin_addr_o);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    check_idle("R2 idle after reset");
    // R4 / R5 granularity and expand-up bound
    apply(mk_lo(b, 20'h0), mk_hi(b, 20'h0, 0, 1, 1, 1, 4'b0010), 32'h0, 2'd0, 2'd0, "R5 lim0 byte");
    apply(mk_lo(b, 20'h0), mk_hi(b, 20'h0, 0, 1, 1, 1, 4'b0010), 32'h0, 2'd1, 2'd0, "R5 lim0 word");
    apply(mk_lo(b, 20'h0), mk_hi(b, 20'h0, 1, 1, 1, 1, 4'b0010), 32'hFFF, 2'd0, 2'd0, "R4 G1 top byte");
    apply(mk_lo(b, 20'h0), mk_hi(b, 20'h0, 1, 1, 1, 1, 4'b0010), 32'hFFD, 2'd2, 2'd0, "R4 G1 dword over");
    apply(mk_lo(b, 20'h0), mk_hi(b, 20'h0, 1, 1, 1, 1, 4'b0010), 32'hFFC, 2'd3, 2'd0, "R3 size3 as 4");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b0010), 32'hFFFF_FFFF, 2'd1, 2'd0, "R5 wrap");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b0010), 32'hFFFF_FFFF, 2'd0, 2'd0, "R5 last byte");
    // R6 expand-down
    apply(mk_lo(b, 20'h0FFF), mk_hi(b, 20'h0FFF, 0, 0, 1, 1, 4'b0110), 32'h0FFF, 2'd0, 2'd1, "R6 at limit");
    apply(mk_lo(b, 20'h0FFF), mk_hi(b, 20'h0FFF, 0, 0, 1, 1, 4'b0110), 32'h1000, 2'd0, 2'd1, "R6 limit+1");
    apply(mk_lo(b, 20'h0FFF), mk_hi(b, 20'h0FFF, 0, 0, 1, 1, 4'b0110), 32'hFFFE, 2'd1, 2'd1, "R6 small top");
    apply(mk_lo(b, 20'h0FFF), mk_hi(b, 20'h0FFF, 0, 0, 1, 1, 4'b0110), 32'hFFFE, 2'd2, 2'd1, "R6 small over");
    apply(mk_lo(b, 20'h0FFF), mk_hi(b, 20'h0FFF, 0, 1, 1, 1, 4'b0110), 32'hFFFF_FFFC, 2'd2, 2'd1, "R6 big top");
    // R7 / R10 / R11 priority
    apply(mk_lo(b, 20'h0), mk_hi(b, 20'h0, 0, 1, 0, 0, 4'b1000), 32'hFFFF, 2'd2, 2'd1, "R7 np over all");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 0, 4'b0010), 32'h10, 2'd0, 2'd0, "R10 system");
    // R8 code
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b1000), 32'h40, 2'd2, 2'd2, "R8 exec");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b1010), 32'h40, 2'd2, 2'd1, "R8 write");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b1000), 32'h40, 2'd0, 2'd0, "R8 read R0");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b1110), 32'h40, 2'd0, 2'd3, "R8 R3 kind3 read");
    // R9 data
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b0010), 32'h40, 2'd0, 2'd2, "R9 exec");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b0000), 32'h40, 2'd0, 2'd1, "R9 write W0");
    apply(mk_lo(b, 20'hFFFFF), mk_hi(b, 20'hFFFFF, 1, 1, 1, 1, 4'b0000), 32'h40, 2'd0, 2'd0, "R9 read W0");
    // R1 address wrap
    apply(mk_lo(32'hFFFF_FF00, 20'hFFFFF), mk_hi(32'hFFFF_FF00, 20'hFFFFF, 1, 1, 1, 1, 4'b0010),
          32'h0000_0200, 2'd2, 2'd0, "R1 addr wrap");
    check_idle("R2 idle between");
    // random mix near the boundary
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rb, off, eff;
      logic [19:0] lim;
      logic g, db, p, s;
      logic [3:0] typ;
      rb = $urandom; lim = 20'($urandom); g = 1'($urandom); db = 1'($urandom);
      p = ($urandom % 8) != 0; s = ($urandom % 8) != 0; typ = 4'($urandom);
      eff = g ? ({12'd0, lim} << 12) | 32'hFFF : {12'd0, lim};
      case ($urandom % 4)
        0: off = eff + 32'($urandom % 8) - 32'd4;
        1: off = 32'h0000_FFFF - 32'($urandom % 6);
        2: off = 32'hFFFF_FFFF - 32'($urandom % 6);
        default: off = $urandom;
      endcase
      apply(mk_lo(rb, lim), mk_hi(rb, lim, g, db, p, s, typ), off, 2'($urandom), 2'($urandom),
            "R11 random R1 R5 R6");
      if (($urandom % 16) == 0) check_idle("R2 random gap");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule